// File: doc/BRIEF.md
# Clock output enable and mode controller

This block sits between a set of configuration bits and the clock output pads of a clock generator. It receives free-running source clocks: a CPU clock, a PCI clock, a 48 MHz clock and a 24 MHz clock. It passes each of them to one or more outputs. Every output has its own run/stop bit. A stop or a restart takes effect only while the source clock is low, so an output parks low and never emits a runt pulse.

A two-bit mode field does three things:

- It drives a common output-enable vector that can float every pad at once.
- It raises a spread-spectrum flag or a test flag for the synthesiser logic next to this block.
- It leaves the clock gating itself untouched.

An active-low CPU stop input is synchronised into the CPU clock domain. It halts the CPU outputs. A control bit lets CPU output 0 ignore that input. The memory feedback output and the PCI outputs never react to the stop input.

Each of the two fixed-frequency outputs selects 48 MHz or 24 MHz through its own bit. The switch is made through a glitch-free two-input selector: the old clock is released only while it is low, and the new one is taken only while it is low.

Top module: `clkout_ctl`

## Requirements
- R1: `out_oe` has every bit at 1 for mode values 2'b00, 2'b01 and 2'b10. It has every bit at 0 for mode 2'b11, whatever the enable bits and `cpu_stop_n` are.
- R2: `ss_on` is 1 exactly when mode is 2'b10. `test_on` is 1 exactly when mode is 2'b01. Both flags are 0 for modes 2'b00 and 2'b11.
- R3: A PCI output (`pci_ck[i]` or `pci_free_ck`) follows `pci_clk` while its enable bit is 1, and is held at 0 while the bit is 0. A new enable value is taken at the next falling edge of `pci_clk`.
- R4: No gated output is ever 1 while its source clock is 0. Starting and stopping therefore never shorten a high phase.
- R5: `cpu_stop_n` is sampled by two rising edges of `cpu_clk` and applied at the following falling edge. While it is low, every CPU output other than output 0 is held at 0. An enabled output runs while `cpu_stop_n` is 1.
- R6: With `cpu0_stop_honor` = 0 and `cpu_en[0]` = 1, `cpu_ck[0]` keeps running while `cpu_stop_n` is low. With `cpu0_stop_honor` = 1, `cpu_ck[0]` stops like the other CPU outputs.
- R7: `mem_fb_ck` follows `cpu_clk` when `mem_fb_en` = 1 and is held at 0 otherwise; it ignores `cpu_stop_n`. The enable is taken at a falling edge of `cpu_clk`.
- R8: After settling, `fx_ck[j]` follows `clk48` when `fx_sel48[j]` = 1 and `clk24` when it is 0. It is gated by `fx_en[j]`, and the enable is taken at the falling edge of each source.
- R9: During a change of `fx_sel48`, `fx_ck` shows no high pulse shorter than a high phase of `clk48`.
- R10: While `rst` is held, once every source clock has fallen at least once, every gated output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Synchronous active-high reset, sampled in each clock domain |
| cpu_clk | input | 1 | Free-running CPU source clock |
| pci_clk | input | 1 | Free-running PCI source clock |
| clk48 | input | 1 | Free-running 48 MHz source |
| clk24 | input | 1 | Free-running 24 MHz source |
| mode | input | 2 | Global mode: 00 plain, 01 test, 10 spread, 11 float all outputs |
| cpu_en | input | N_CPU | Run (1) / stop (0) per CPU output |
| cpu0_stop_honor | input | 1 | 1: CPU output 0 obeys `cpu_stop_n`; 0: it ignores it |
| cpu_stop_n | input | 1 | Asynchronous active-low CPU stop request |
| mem_fb_en | input | 1 | Run/stop for the memory feedback output |
| pci_en | input | N_PCI | Run/stop per PCI output |
| pci_free_en | input | 1 | Run/stop for the free-running PCI output |
| fx_en | input | N_FX | Run/stop per fixed-frequency output |
| fx_sel48 | input | N_FX | 1 selects 48 MHz, 0 selects 24 MHz, per fixed-frequency output |
| cpu_ck | output | N_CPU | Gated CPU clocks |
| mem_fb_ck | output | 1 | Gated memory feedback clock |
| pci_ck | output | N_PCI | Gated PCI clocks |
| pci_free_ck | output | 1 | Gated free-running PCI clock |
| fx_ck | output | N_FX | Gated, frequency-selected fixed clocks |
| out_oe | output | N_CPU+N_PCI+N_FX+2 | Pad drive enables (CPU, feedback, PCI, free PCI, fixed, LSB first) |
| ss_on | output | 1 | Spread-spectrum request flag |
| test_on | output | 1 | Test-mode flag |

## Verification
Two situations are the hardest to reach from the ports.

The first is a frequency change on a fixed output whose 24 MHz fall coincides with a 48 MHz fall. There, both selector halves update on the same instant and each must see the other's old state. The bench derives `clk48` and `clk24` from one counter, so their falling edges line up every second 48 MHz period. Selector flips are issued at every phase offset, and the high-pulse width on `fx_ck` is measured at half-cycle resolution.

The second is the stop path. Here `cpu_stop_n`, `cpu0_stop_honor` and `cpu_en` are toggled in random order and at random spacing. This drives the two-stage synchroniser through short low pulses and through honour-bit changes made while a stop is in progress.

// File: rtl/clkout_ctl_pkg.sv
package clkout_ctl_pkg;

    typedef enum logic [1:0] {
        MODE_PLAIN  = 2'b00,
        MODE_TEST   = 2'b01,
        MODE_SPREAD = 2'b10,
        MODE_FLOAT  = 2'b11
    } clk_mode_e;

    typedef struct packed {
        logic drive;
        logic spread;
        logic test;
    } mode_flags_t;

    // Number of pads controlled: CPU group, feedback, PCI group, free PCI, fixed group.
    function automatic int pad_count(input int n_cpu, input int n_pci, input int n_fx);
        return n_cpu + n_pci + n_fx + 2;
    endfunction

    function automatic mode_flags_t decode_mode(input logic [1:0] m);
        mode_flags_t f;
        f = '{drive: 1'b1, spread: 1'b0, test: 1'b0};
        case (clk_mode_e'(m))
            MODE_FLOAT:  f.drive  = 1'b0;
            MODE_SPREAD: f.spread = 1'b1;
            MODE_TEST:   f.test   = 1'b1;
            default:     f.drive  = 1'b1;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/clkout_ctl_sync.sv
module clkout_ctl_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clkout_ctl_gate.sv
module clkout_ctl_gate (
    input  logic clk_src,
    input  logic rst,
    input  logic en,
    output logic clk_out
);
    // Enable captured on the falling edge: the AND input only moves while clk_src is low.
    logic en_q;

    always_ff @(negedge clk_src) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= en;
    end

    assign clk_out = clk_src & en_q;
endmodule

// File: rtl/clkout_ctl_fxmux.sv
module clkout_ctl_fxmux (
    input  logic rst,
    input  logic clk_hi,
    input  logic clk_lo,
    input  logic sel_hi,
    input  logic en,
    output logic clk_out
);
    logic take_hi, take_lo;
    logic g_hi, g_lo;

    // Each half claims its clock only after the other half has let go, both on falling edges.
    always_ff @(negedge clk_hi) begin
        if (rst) take_hi <= 1'b0;
        else     take_hi <= sel_hi & ~take_lo;
    end

    always_ff @(negedge clk_lo) begin
        if (rst) take_lo <= 1'b0;
        else     take_lo <= ~sel_hi & ~take_hi;
    end

    clkout_ctl_gate gate_hi_i (.clk_src(clk_hi), .rst(rst), .en(en), .clk_out(g_hi));
    clkout_ctl_gate gate_lo_i (.clk_src(clk_lo), .rst(rst), .en(en), .clk_out(g_lo));

    assign clk_out = (g_hi & take_hi) | (g_lo & take_lo);
endmodule

// File: rtl/clkout_ctl.sv
module clkout_ctl
    import clkout_ctl_pkg::*;
#(
    parameter int N_CPU       = 2,
    parameter int N_PCI       = 6,
    parameter int N_FX        = 2,
    parameter int STOP_STAGES = 2,
    localparam int N_OUT      = N_CPU + N_PCI + N_FX + 2
) (
    input  logic             rst,
    input  logic             cpu_clk,
    input  logic             pci_clk,
    input  logic             clk48,
    input  logic             clk24,
    input  logic [1:0]       mode,
    input  logic [N_CPU-1:0] cpu_en,
    input  logic             cpu0_stop_honor,
    input  logic             cpu_stop_n,
    input  logic             mem_fb_en,
    input  logic [N_PCI-1:0] pci_en,
    input  logic             pci_free_en,
    input  logic [N_FX-1:0]  fx_en,
    input  logic [N_FX-1:0]  fx_sel48,
    output logic [N_CPU-1:0] cpu_ck,
    output logic             mem_fb_ck,
    output logic [N_PCI-1:0] pci_ck,
    output logic             pci_free_ck,
    output logic [N_FX-1:0]  fx_ck,
    output logic [N_OUT-1:0] out_oe,
    output logic             ss_on,
    output logic             test_on
);
    localparam int PADS = pad_count(N_CPU, N_PCI, N_FX);

    mode_flags_t flags;
    logic        run_ok;

    assign flags   = decode_mode(mode);
    assign ss_on   = flags.spread;
    assign test_on = flags.test;
    assign out_oe  = {PADS{flags.drive}};

    clkout_ctl_sync #(.STAGES(STOP_STAGES), .RST_VAL(1'b1)) stop_sync_i (
        .clk(cpu_clk), .rst(rst), .d(cpu_stop_n), .q(run_ok)
    );

    for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
        logic want;
        if (i == 0) begin : g_free
            assign want = cpu_en[i] & (run_ok | ~cpu0_stop_honor);
        end else begin : g_stop
            assign want = cpu_en[i] & run_ok;
        end
        clkout_ctl_gate gate_i (.clk_src(cpu_clk), .rst(rst), .en(want), .clk_out(cpu_ck[i]));
    end

    clkout_ctl_gate fb_gate_i (.clk_src(cpu_clk), .rst(rst), .en(mem_fb_en), .clk_out(mem_fb_ck));

    for (genvar i = 0; i < N_PCI; i++) begin : g_pci
        clkout_ctl_gate gate_i (.clk_src(pci_clk), .rst(rst), .en(pci_en[i]), .clk_out(pci_ck[i]));
    end

    clkout_ctl_gate pfree_gate_i (.clk_src(pci_clk), .rst(rst), .en(pci_free_en), .clk_out(pci_free_ck));

    for (genvar j = 0; j < N_FX; j++) begin : g_fx
        clkout_ctl_fxmux mux_i (
            .rst(rst), .clk_hi(clk48), .clk_lo(clk24),
            .sel_hi(fx_sel48[j]), .en(fx_en[j]), .clk_out(fx_ck[j])
        );
    end
endmodule

// File: rtl/clkout_ctl_chk.sv
module clkout_ctl_chk #(
    parameter int N_CPU = 2,
    parameter int N_PCI = 6,
    parameter int N_FX  = 2
) (
    input logic                         rst,
    input logic                         cpu_clk,
    input logic                         pci_clk,
    input logic                         clk48,
    input logic                         clk24,
    input logic [1:0]                   mode,
    input logic [N_CPU-1:0]             cpu_en,
    input logic                         cpu0_stop_honor,
    input logic                         cpu_stop_n,
    input logic [N_CPU-1:0]             cpu_ck,
    input logic [N_PCI-1:0]             pci_ck,
    input logic                         pci_free_ck,
    input logic [N_FX-1:0]              fx_ck,
    input logic [N_CPU+N_PCI+N_FX+1:0]  out_oe,
    input logic                         ss_on,
    input logic                         test_on
);
    logic [2:0] stop_cnt;
    logic [2:0] free_cnt;

    always_ff @(posedge cpu_clk) begin
        if (rst)              stop_cnt <= '0;
        else if (!cpu_stop_n) stop_cnt <= (stop_cnt == 3'd7) ? stop_cnt : stop_cnt + 3'd1;
        else                  stop_cnt <= '0;
    end

    always_ff @(posedge cpu_clk) begin
        if (rst)                                free_cnt <= '0;
        else if (!cpu0_stop_honor && cpu_en[0]) free_cnt <= (free_cnt == 3'd7) ? free_cnt : free_cnt + 3'd1;
        else                                    free_cnt <= '0;
    end

    p_float_all_r1: assert property (@(posedge cpu_clk) disable iff (rst)
        (mode == 2'b11) |-> (out_oe == '0));

    p_drive_all_r1: assert property (@(posedge cpu_clk) disable iff (rst)
        (mode != 2'b11) |-> (&out_oe));

    p_spread_flag_r2: assert property (@(posedge cpu_clk) disable iff (rst)
        ss_on |-> (mode == 2'b10));

    p_test_flag_r2: assert property (@(posedge cpu_clk) disable iff (rst)
        test_on |-> (mode == 2'b01));

    p_flags_excl_r2: assert property (@(posedge cpu_clk) disable iff (rst)
        $onehot0({ss_on, test_on}));

    p_pci_low_r4: assert property (@(negedge cpu_clk) disable iff (rst)
        !pci_clk |-> (pci_ck == '0 && !pci_free_ck));

    p_fx_low_r9: assert property (@(negedge cpu_clk) disable iff (rst)
        (!clk48 && !clk24) |-> (fx_ck == '0));

    p_cpu_stopped_r5: assert property (@(negedge cpu_clk) disable iff (rst)
        (stop_cnt >= 3'd3) |-> (cpu_ck[N_CPU-1:1] == '0));

    p_cpu0_free_r6: assert property (@(negedge cpu_clk) disable iff (rst)
        (free_cnt >= 3'd2) |-> cpu_ck[0]);
endmodule

bind clkout_ctl clkout_ctl_chk #(.N_CPU(N_CPU), .N_PCI(N_PCI), .N_FX(N_FX)) chk_i (.*);

// File: tb/clkout_ctl_tb_top.sv
`timescale 1ns/1ps
module clkout_ctl_tb_top;
    localparam int N_CPU = 2;
    localparam int N_PCI = 6;
    localparam int N_FX  = 2;
    localparam int N_OUT = N_CPU + N_PCI + N_FX + 2;
    localparam int SETTLE = 24;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst = 1'b1;
    logic             pci_clk = 1'b0, clk48 = 1'b0, clk24 = 1'b0;
    logic [1:0]       mode = 2'b00;
    logic [N_CPU-1:0] cpu_en = '1;
    logic             cpu0_stop_honor = 1'b1;
    logic             cpu_stop_n = 1'b1;
    logic             mem_fb_en = 1'b1;
    logic [N_PCI-1:0] pci_en = '1;
    logic             pci_free_en = 1'b1;
    logic [N_FX-1:0]  fx_en = '1;
    logic [N_FX-1:0]  fx_sel48 = '1;
    logic [N_CPU-1:0] cpu_ck;
    logic             mem_fb_ck;
    logic [N_PCI-1:0] pci_ck;
    logic             pci_free_ck;
    logic [N_FX-1:0]  fx_ck;
    logic [N_OUT-1:0] out_oe;
    logic             ss_on, test_on;

    clkout_ctl #(.N_CPU(N_CPU), .N_PCI(N_PCI), .N_FX(N_FX)) dut_i (
        .rst(rst), .cpu_clk(clk), .pci_clk(pci_clk), .clk48(clk48), .clk24(clk24),
        .mode(mode), .cpu_en(cpu_en), .cpu0_stop_honor(cpu0_stop_honor),
        .cpu_stop_n(cpu_stop_n), .mem_fb_en(mem_fb_en), .pci_en(pci_en),
        .pci_free_en(pci_free_en), .fx_en(fx_en), .fx_sel48(fx_sel48),
        .cpu_ck(cpu_ck), .mem_fb_ck(mem_fb_ck), .pci_ck(pci_ck), .pci_free_ck(pci_free_ck),
        .fx_ck(fx_ck), .out_oe(out_oe), .ss_on(ss_on), .test_on(test_on)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [31:0] cyc = '0;

    // Behavioural reference state
    logic             m_s1 = 1'b1, m_s2 = 1'b1;
    logic [N_CPU-1:0] m_cpu = '0;
    logic             m_fb = 1'b0;
    logic [N_PCI-1:0] m_pci = '0;
    logic             m_pfree = 1'b0;
    logic [N_FX-1:0]  m_e48 = '0, m_e24 = '0;
    logic [N_FX-1:0]  prev_sel = '1;
    int               settle[N_FX];
    int               hi_run[N_FX];

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at t=%0t act=%0h exp=%0h", req, what, $time, act, exp);
        end
    endtask

    task automatic compare(input bit hi);
        if (cyc < 10) return;
        for (int i = 0; i < N_CPU; i++)
            chk(i == 0 ? "R6" : "R5", $sformatf("cpu_ck[%0d]", i), 32'(cpu_ck[i]), 32'(hi & m_cpu[i]));
        chk("R7", "mem_fb_ck", 32'(mem_fb_ck), 32'(hi & m_fb));
        for (int i = 0; i < N_PCI; i++) begin
            chk("R3", $sformatf("pci_ck[%0d]", i), 32'(pci_ck[i]), 32'(pci_clk & m_pci[i]));
            if (!pci_clk) chk("R4", "pci high in low phase", 32'(pci_ck[i]), 32'd0);
        end
        chk("R3", "pci_free_ck", 32'(pci_free_ck), 32'(pci_clk & m_pfree));
        if (!hi) chk("R4", "cpu group high in low phase", 32'({cpu_ck, mem_fb_ck}), 32'd0);
        for (int j = 0; j < N_FX; j++) begin
            if (settle[j] == 0 && !rst)
                chk("R8", $sformatf("fx_ck[%0d]", j), 32'(fx_ck[j]),
                    32'(fx_sel48[j] ? (clk48 & m_e48[j]) : (clk24 & m_e24[j])));
            if (fx_ck[j]) hi_run[j]++;
            else begin
                if (hi_run[j] > 0 && hi_run[j] < 4)
                    chk("R9", $sformatf("fx_ck[%0d] short high samples", j), 32'(hi_run[j]), 32'd4);
                hi_run[j] = 0;
            end
        end
        if (!rst) begin
            chk("R1", "out_oe", 32'(out_oe), (mode == 2'b11) ? 32'd0 : 32'((1 << N_OUT) - 1));
            chk("R2", "flags", 32'({ss_on, test_on}), 32'({mode == 2'b10, mode == 2'b01}));
        end
    endtask

    task automatic tick();
        logic op, o48, o24;
        @(posedge clk);
        op = pci_clk; o48 = clk48; o24 = clk24;
        cyc = cyc + 1;
        pci_clk = cyc[0]; clk48 = cyc[1]; clk24 = cyc[2];
        if (rst) begin m_s1 = 1'b1; m_s2 = 1'b1; end
        else begin m_s2 = m_s1; m_s1 = cpu_stop_n; end
        if (op && !pci_clk) begin
            m_pci   = rst ? '0 : pci_en;
            m_pfree = rst ? 1'b0 : pci_free_en;
        end
        for (int j = 0; j < N_FX; j++) begin
            if (o48 && !clk48) m_e48[j] = rst ? 1'b0 : fx_en[j];
            if (o24 && !clk24) m_e24[j] = rst ? 1'b0 : fx_en[j];
            if (rst || fx_sel48[j] != prev_sel[j]) settle[j] = SETTLE;
            else if (settle[j] > 0) settle[j]--;
        end
        prev_sel = fx_sel48;
        #1 compare(1'b1);
        @(negedge clk);
        if (rst) begin m_cpu = '0; m_fb = 1'b0; end
        else begin
            m_fb = mem_fb_en;
            for (int i = 0; i < N_CPU; i++)
                m_cpu[i] = cpu_en[i] & (m_s2 | (i == 0 && !cpu0_stop_honor));
        end
        #1 compare(1'b0);
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog act=running exp=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned lf;
        for (int j = 0; j < N_FX; j++) begin settle[j] = SETTLE; hi_run[j] = 0; end
        run(12);
        // R10: every source has fallen by now; all outputs low under reset
        chk("R10", "outputs in reset", 32'({cpu_ck, mem_fb_ck, pci_ck, pci_free_ck, fx_ck}), 32'd0);
        run(4);
        rst = 1'b0;
        run(40);
        // R1 / R2: mode sweep, float mode with stop asserted
        for (int m = 0; m < 4; m++) begin
            mode = 2'(m);
            if (m == 3) cpu_stop_n = 1'b0;
            run(6);
            chk("R1", "oe after mode change", 32'(out_oe), (m == 3) ? 32'd0 : 32'((1 << N_OUT) - 1));
            chk("R2", "spread flag", 32'(ss_on), 32'(m == 2));
        end
        mode = 2'b00; cpu_stop_n = 1'b1; run(10);
        // R3: PCI patterns
        pci_en = 6'b101010; pci_free_en = 1'b0; run(20);
        pci_en = 6'b010101; run(20);
        pci_en = '1; pci_free_en = 1'b1; run(10);
        // R5 / R6 / R7: stop handling
        cpu_stop_n = 1'b0; run(20);
        cpu0_stop_honor = 1'b0; run(20);
        mem_fb_en = 1'b0; run(10);
        cpu_stop_n = 1'b1; mem_fb_en = 1'b1; run(20);
        cpu_en = 2'b01; run(10); cpu_en = '1; run(10);
        // R8 / R9: frequency selection
        fx_sel48 = 2'b01; run(40);
        fx_sel48 = 2'b10; run(40);
        fx_en = 2'b01; run(30);
        fx_sel48 = 2'b00; fx_en = '1; run(40);
        for (int d = 0; d < 8; d++) begin
            fx_sel48 = ~fx_sel48; run(8 + d);
        end
        run(40);
        // mixed random stimulus
        lf = 32'h1234_5678;
        for (int it = 0; it < 400; it++) begin
            lf = lf * 32'd1103515245 + 32'd12345;
            case ((lf >> 16) % 8)
                0: mode            = lf[9:8];
                1: cpu_en          = lf[11:10];
                2: cpu0_stop_honor = lf[12];
                3: cpu_stop_n      = lf[13];
                4: pci_en          = lf[29:24];
                5: begin pci_free_en = lf[14]; mem_fb_en = lf[15]; end
                6: fx_en           = lf[9:8];
                default: fx_sel48  = lf[11:10];
            endcase
            run(1 + int'(lf[30:28]) * 2);
        end
        run(40);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule